// File: doc/BRIEF.md
# NAND Flash Host Register Bridge

This block sits between a simple memory-mapped host bus and an 8-bit raw NAND flash device. The host sees a small window of byte registers: a data port, a mode register whose bits drive the flash control pins directly, a read-only status byte that reports the busy state of the flash, a pending-interrupt register and an interrupt enable register. Software steers the flash by writing mode values (command, address or data cycles, standby, card power) and then moving bytes through the data port.

A data-port access is turned into a run of flash byte cycles: one for a byte access, two for a halfword, four for a word, least significant byte first in both directions. Each read or write strobe is held low for a fixed, parameterised number of clocks, with one idle clock between strobes, and the host is held off until the last byte has finished. A rising edge on the flash ready/busy line latches a ready flag, which raises a registered interrupt output when it has been enabled.

Top module: `nand_host_bridge`

## Requirements
- R1: After reset the flash is deselected (`nand_ce_n`=1), both strobes are high, `irq`=0, `card_pwr`=0, `bus_ack`=0, and the mode (offset 4), pending (offset 6) and enable (offset 7) registers read 0x00.
- R2: The mode register at offset 4 reads back what was written, and its bits drive the pins while idle: bit4 set gives `nand_ce_n`=0, bit0 drives `nand_cle`, bit1 drives `nand_ale`; 0x95 is a command cycle (CLE high during the strobe), 0x96 an address cycle, 0x94 a data cycle, 0x00 standby with the chip deselected.
- R3: A mode write with bit3 set loads `card_pwr` from bit2 (0x0C powers on, 0x08 powers off); a mode write with bit3 clear leaves `card_pwr` unchanged.
- R4: A data-port write (offsets 0 to 3) with `bus_size` 0, 1 or 2 (2 and 3 both mean word) produces 1, 2 or 4 flash write cycles, sending `bus_wdata[7:0]` first and then each higher byte in order.
- R5: A data-port read with `bus_size` 0, 1 or 2 performs 1, 2 or 4 flash read cycles; the first byte returned by the flash lands in `bus_rdata[7:0]`, later bytes in successively higher bytes, unused bytes read 0.
- R6: Every flash strobe is low for exactly `STROBE_CLKS` clock cycles, consecutive strobes of one access are separated by one high cycle, and the two strobes are never low together.
- R7: When mode bit7 (write enable) is clear, a data-port write completes on the bus with no write strobe to the flash.
- R8: Status (offset 5) bit7 reads 1 while the synchronised `nand_rb` is low (busy) and 0 when it is high; the other bits read 0.
- R9: A rising edge of the synchronised `nand_rb` sets the ready flag, read at bit0 of offset 6; `nand_rb` staying high does not set it again.
- R10: Writing a byte with bit0 set to offset 6 clears the ready flag; if a ready edge arrives in the same cycle as the clear, the flag stays set.
- R11: `irq` is registered and equals ready flag AND enable bit7 AND enable bit0 (offset 7) from the previous cycle; writing 0x81 enables it, 0x00 disables it.
- R12: `bus_ack` is a one-cycle pulse; a register access at offsets 4 to 7 is acknowledged in the cycle after it is accepted, and no new request is accepted while a data access runs or while `bus_ack` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Host request, held until `bus_ack` |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte offset in the register window |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | One-cycle completion pulse |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Byte driven to the flash |
| nand_dq_oe | output | 1 | Output enable for `nand_dq_out` |
| nand_dq_in | input | 8 | Byte returned by the flash |
| nand_rb | input | 1 | Ready/busy from the flash, 1 = ready |
| card_pwr | output | 1 | Card power control |
| irq | output | 1 | Ready interrupt |

## Verification
The hardest case to reach is a ready edge that lands in the very cycle in which a clear of the pending register is accepted, since the edge passes through the synchroniser before it reaches the flag. The bench raises `nand_rb` at a known falling clock edge, counts the synchroniser and edge-detect stages, and times its clear request so it is accepted on the same edge that sets the flag; the flag must then read back as set. Strobe width and gap are measured at the pins by counting low and high clocks between strobe edges.

// File: rtl/nhb_pkg.sv
// Shared types and constants of the NAND host bridge.
// Assumes a 3-bit byte offset into an 8-byte register window.
package nhb_pkg;

    // Data-port access width as coded on bus_size
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WORD_ALT = 2'd3
    } acc_size_e;

    // Byte sequencer states
    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_STROBE = 2'd1,
        SQ_GAP    = 2'd2
    } seq_state_e;

    // Offsets within the control half of the window (bus_addr[1:0] with bus_addr[2]=1)
    localparam logic [1:0] OFF_MODE    = 2'd0;
    localparam logic [1:0] OFF_STATUS  = 2'd1;
    localparam logic [1:0] OFF_PENDING = 2'd2;
    localparam logic [1:0] OFF_ENABLE  = 2'd3;

    // Mode register bit positions
    localparam int MB_WREN  = 7;
    localparam int MB_CE    = 4;
    localparam int MB_PWSEL = 3;
    localparam int MB_PWVAL = 2;
    localparam int MB_ALE   = 1;
    localparam int MB_CLE   = 0;

    // Number of flash byte cycles for an access size
    function automatic logic [2:0] bytes_for(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: bytes_for = 3'd1;
            SZ_HALF: bytes_for = 3'd2;
            default: bytes_for = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/nhb_regs.sv
// Control registers of the NAND host bridge: mode, card power, interrupt
// enable, and the read multiplexer for the control half of the window.
// Assumes acc_en is a one-cycle pulse for an accepted control access.
module nhb_regs
    import nhb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_en,
    input  logic       acc_wr,
    input  logic [1:0] acc_off,
    input  logic [7:0] acc_wdata,
    input  logic       busy_in,
    input  logic       flag_in,
    output logic [7:0] mode_q,
    output logic [7:0] mask_q,
    output logic       pwr_q,
    output logic       clr_req,
    output logic [7:0] rd_byte
);

    logic wr_mode;
    logic wr_mask;

    assign wr_mode = acc_en && acc_wr && (acc_off == OFF_MODE);
    assign wr_mask = acc_en && acc_wr && (acc_off == OFF_ENABLE);
    assign clr_req = acc_en && acc_wr && (acc_off == OFF_PENDING) && acc_wdata[0];

    // Mode register and the sticky card power bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 8'h00;
            pwr_q  <= 1'b0;
        end else if (wr_mode) begin
            mode_q <= acc_wdata;
            if (acc_wdata[MB_PWSEL])
                pwr_q <= acc_wdata[MB_PWVAL];
        end
    end

    // Interrupt enable register
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= 8'h00;
        else if (wr_mask)
            mask_q <= acc_wdata;
    end

    // Read multiplexer for the control registers
    always_comb begin
        case (acc_off)
            OFF_MODE:    rd_byte = mode_q;
            OFF_STATUS:  rd_byte = {busy_in, 7'b0};
            OFF_PENDING: rd_byte = {7'b0, flag_in};
            default:     rd_byte = mask_q;
        endcase
    end

endmodule

// File: rtl/nhb_seq.sv
// Flash byte sequencer: splits one data-port access into 1, 2 or 4 byte
// cycles, LSB first, each strobe low for STROBE_CLKS clocks with one high
// clock between strobes. done pulses for one cycle after the last byte.
// Assumes start is only raised while busy is low.
module nhb_seq
    import nhb_pkg::*;
#(
    parameter int BUS_W       = 32,
    parameter int STROBE_CLKS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             wr,
    input  logic [2:0]       nbytes,
    input  logic [BUS_W-1:0] wdata,
    input  logic             wr_allow,
    input  logic [7:0]       dq_in,
    output logic             busy,
    output logic             done,
    output logic             we_n,
    output logic             re_n,
    output logic [7:0]       dq_out,
    output logic             dq_oe,
    output logic [BUS_W-1:0] rdata
);

    localparam int MAX_BYTES = BUS_W / 8;
    localparam int IDX_W     = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
    localparam int CNT_W     = $clog2(STROBE_CLKS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CLKS - 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic [2:0]       nb_q;
    logic             wr_q;
    logic             allow_q;
    logic [BUS_W-1:0] wbuf_q;
    logic [BUS_W-1:0] rbuf_q;
    logic             last_byte;

    assign last_byte = ({{(3-IDX_W){1'b0}}, idx_q} == (nb_q - 3'd1));

    // State, strobe counter and byte index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            nb_q    <= 3'd1;
            wr_q    <= 1'b0;
            allow_q <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                SQ_IDLE: if (start) begin
                    state_q <= SQ_STROBE;
                    cnt_q   <= '0;
                    idx_q   <= '0;
                    nb_q    <= nbytes;
                    wr_q    <= wr;
                    allow_q <= wr_allow;
                end
                SQ_STROBE: begin
                    if (cnt_q == CNT_LAST)
                        state_q <= SQ_GAP;
                    else
                        cnt_q <= cnt_q + 1'b1;
                end
                default: begin
                    if (last_byte) begin
                        state_q <= SQ_IDLE;
                        done    <= 1'b1;
                    end else begin
                        state_q <= SQ_STROBE;
                        cnt_q   <= '0;
                        idx_q   <= idx_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // Write byte shifter: the byte on the pins is always bits 7:0
    always_ff @(posedge clk) begin
        if (!rst_n)
            wbuf_q <= '0;
        else if (state_q == SQ_IDLE && start)
            wbuf_q <= wdata;
        else if (state_q == SQ_GAP)
            wbuf_q <= wbuf_q >> 8;
    end

    // Read assembly: capture on the last low clock of each read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            rbuf_q <= '0;
        else if (state_q == SQ_IDLE && start && !wr)
            rbuf_q <= '0;
        else if (state_q == SQ_STROBE && !wr_q && cnt_q == CNT_LAST)
            rbuf_q[8*idx_q +: 8] <= dq_in;
    end

    assign busy   = (state_q != SQ_IDLE);
    assign re_n   = !(state_q == SQ_STROBE && !wr_q);
    assign we_n   = !(state_q == SQ_STROBE && wr_q && allow_q);
    assign dq_oe  = busy && wr_q && allow_q;
    assign dq_out = wbuf_q[7:0];
    assign rdata  = rbuf_q;

endmodule

// File: rtl/nhb_irq.sv
// Ready/busy synchroniser, rising-edge ready flag and registered interrupt.
// Assumes the flash is ready at reset, so the synchroniser resets to 1 and
// no edge is reported when the line is already high. A ready edge wins over
// a clear in the same cycle.
module nhb_irq #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rb_raw,
    input  logic       clr_req,
    input  logic [7:0] mask,
    output logic       rb_ready,
    output logic       flag_q,
    output logic       irq_q
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rb_prev_q;
    logic                   rise;

    // Synchroniser chain for the asynchronous ready/busy line
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_q <= '1;
        else
            sync_q <= {sync_q[SYNC_STAGES-2:0], rb_raw};
    end

    assign rb_ready = sync_q[SYNC_STAGES-1];
    assign rise     = rb_ready && !rb_prev_q;

    // Previous synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n)
            rb_prev_q <= 1'b1;
        else
            rb_prev_q <= rb_ready;
    end

    // Pending ready flag, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (rise)
            flag_q <= 1'b1;
        else if (clr_req)
            flag_q <= 1'b0;
    end

    // Registered interrupt output, gated by global and per-source enable
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= flag_q && mask[7] && mask[0];
    end

endmodule

// File: rtl/nand_host_bridge.sv
// Top of the NAND host bridge. Accepts one host request at a time; offsets
// 4..7 are control registers answered in one cycle, offsets 0..3 are the data
// port handled by the byte sequencer. Assumes bus_req is held until bus_ack.
module nand_host_bridge
    import nhb_pkg::*;
#(
    parameter int BUS_W       = 32,
    parameter int STROBE_CLKS = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_req,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [1:0]       bus_size,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             bus_ack,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_dq_out,
    output logic             nand_dq_oe,
    input  logic [7:0]       nand_dq_in,
    input  logic             nand_rb,
    output logic             card_pwr,
    output logic             irq
);

    logic             seq_busy;
    logic             seq_done;
    logic [BUS_W-1:0] seq_rdata;
    logic             accept;
    logic             reg_hit;
    logic             data_hit;
    logic             reg_ack_q;
    logic             last_reg_q;
    logic [7:0]       reg_rd_q;
    logic [7:0]       reg_rd_byte;
    logic [7:0]       mode_q;
    logic [7:0]       mask_q;
    logic             clr_req;
    logic             rb_ready;
    logic             ready_flag;

    assign accept   = bus_req && !seq_busy && !bus_ack;
    assign reg_hit  = accept && bus_addr[2];
    assign data_hit = accept && !bus_addr[2];

    // Control access completion and read data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_ack_q  <= 1'b0;
            last_reg_q <= 1'b0;
            reg_rd_q   <= 8'h00;
        end else begin
            reg_ack_q <= reg_hit;
            if (reg_hit) begin
                last_reg_q <= 1'b1;
                reg_rd_q   <= reg_rd_byte;
            end else if (data_hit) begin
                last_reg_q <= 1'b0;
            end
        end
    end

    nhb_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (reg_hit),
        .acc_wr    (bus_wr),
        .acc_off   (bus_addr[1:0]),
        .acc_wdata (bus_wdata[7:0]),
        .busy_in   (!rb_ready),
        .flag_in   (ready_flag),
        .mode_q    (mode_q),
        .mask_q    (mask_q),
        .pwr_q     (card_pwr),
        .clr_req   (clr_req),
        .rd_byte   (reg_rd_byte)
    );

    nhb_seq #(
        .BUS_W       (BUS_W),
        .STROBE_CLKS (STROBE_CLKS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (data_hit),
        .wr       (bus_wr),
        .nbytes   (bytes_for(bus_size)),
        .wdata    (bus_wdata),
        .wr_allow (mode_q[MB_WREN]),
        .dq_in    (nand_dq_in),
        .busy     (seq_busy),
        .done     (seq_done),
        .we_n     (nand_we_n),
        .re_n     (nand_re_n),
        .dq_out   (nand_dq_out),
        .dq_oe    (nand_dq_oe),
        .rdata    (seq_rdata)
    );

    nhb_irq #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rb_raw   (nand_rb),
        .clr_req  (clr_req),
        .mask     (mask_q),
        .rb_ready (rb_ready),
        .flag_q   (ready_flag),
        .irq_q    (irq)
    );

    assign bus_ack   = reg_ack_q || seq_done;
    assign bus_rdata = last_reg_q ? {{(BUS_W-8){1'b0}}, reg_rd_q} : seq_rdata;
    assign nand_ce_n = !mode_q[MB_CE];
    assign nand_cle  = mode_q[MB_CLE];
    assign nand_ale  = mode_q[MB_ALE];

endmodule

// File: rtl/nhb_checker.sv
// Protocol checker for the NAND host bridge, bound to the top module.
module nhb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       nand_we_n,
    input logic       nand_re_n,
    input logic       bus_ack,
    input logic       irq,
    input logic [7:0] mode_q,
    input logic [7:0] mask_q,
    input logic       ready_flag,
    input logic       rb_ready
);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n)); // R6

    AST_NO_ACK_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !bus_ack); // R6

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack); // R12

    AST_WE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> mode_q[7]); // R7

    AST_FLAG_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rb_ready) |=> ready_flag); // R9

    AST_IRQ_FROM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ready_flag)); // R11

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(mask_q[7] && mask_q[0])); // R11

endmodule

bind nand_host_bridge nhb_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .bus_ack    (bus_ack),
    .irq        (irq),
    .mode_q     (mode_q),
    .mask_q     (mask_q),
    .ready_flag (ready_flag),
    .rb_ready   (rb_ready)
);

// File: tb/tb_nand_host_bridge.sv
module tb_nand_host_bridge;

    localparam int TB_STROBE = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [1:0]  bus_size = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        bus_ack;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n;
    logic [7:0]  nand_dq_out;
    logic        nand_dq_oe;
    logic [7:0]  nand_dq_in;
    logic        nand_rb = 1'b1;
    logic        card_pwr;
    logic        irq;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;

    // Flash model logs
    logic [7:0] wlog [0:15];
    logic       wcle [0:15];
    int         wgap [0:15];
    int         wcnt = 0;
    int         lo_run = 0;
    int         hi_run = 0;
    int         last_width = 0;
    int         rd_ptr = 0;
    logic       prev_we = 1'b1;
    logic       prev_re = 1'b1;
    int         last_lat = 0;

    always #2 clk = ~clk;

    nand_host_bridge #(.STROBE_CLKS(TB_STROBE)) dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .nand_ce_n(nand_ce_n),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in), .nand_rb(nand_rb), .card_pwr(card_pwr), .irq(irq)
    );

    function automatic logic [7:0] rpat(input int i);
        rpat = 8'(8'hA3 + i * 8'd29);
    endfunction

    assign nand_dq_in = rpat(rd_ptr);

    // Pin monitor sampled on the falling clock edge
    always @(negedge clk) begin
        if (!nand_we_n && prev_we) begin
            wlog[wcnt % 16] = nand_dq_out;
            wcle[wcnt % 16] = nand_cle;
            wgap[wcnt % 16] = hi_run;
            wcnt = wcnt + 1;
            lo_run = 1;
        end else if (!nand_we_n) begin
            lo_run = lo_run + 1;
        end
        if (nand_we_n && !prev_we) last_width = lo_run;
        hi_run = nand_we_n ? hi_run + 1 : 0;
        if (nand_re_n && !prev_re) rd_ptr = rd_ptr + 1;
        prev_we = nand_we_n;
        prev_re = nand_re_n;
    end

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // Watchdog
    always @(negedge clk) begin
        cycles = cycles + 1;
        if (cycles > 150000) begin
            vectors = vectors + 1;
            miscompares = miscompares + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=below 150000", cycles);
            report();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors = vectors + 1;
        if (act !== exp) begin
            miscompares = miscompares + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input bit wr, input logic [2:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd);
        int n;
        n = 0;
        @(negedge clk);
        bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
        do begin
            @(negedge clk);
            n = n + 1;
        end while (!bus_ack && n < 1000);
        rd = bus_rdata;
        last_lat = n;
        bus_req = 1'b0;
        if (n >= 1000) chk("R12 ack timeout", 32'(n), 32'd0);
    endtask

    task automatic wr8(input logic [2:0] a, input logic [7:0] v);
        logic [31:0] d;
        xfer(1'b1, a, 2'd0, {24'd0, v}, d);
    endtask

    task automatic rd8(input logic [2:0] a, output logic [7:0] v);
        logic [31:0] d;
        xfer(1'b0, a, 2'd0, 32'd0, d);
        v = d[7:0];
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R1 ce_n", {31'd0, nand_ce_n}, 32'd1);
        chk("R1 we_n/re_n", {30'd0, nand_we_n, nand_re_n}, 32'd3);
        chk("R1 irq/pwr/ack", {29'd0, irq, card_pwr, bus_ack}, 32'd0);
        rd8(3'd4, v); chk("R1 mode", {24'd0, v}, 32'd0);
        rd8(3'd6, v); chk("R1 pending", {24'd0, v}, 32'd0);
        rd8(3'd7, v); chk("R1 enable", {24'd0, v}, 32'd0);
    endtask

    task automatic t_ack;
        logic [7:0] v;
        rd8(3'd7, v);
        chk("R12 register ack latency", 32'(last_lat), 32'd1);
        @(negedge clk);
        chk("R12 ack single cycle", {31'd0, bus_ack}, 32'd0);
    endtask

    task automatic t_mode;
        logic [7:0] v;
        logic [31:0] d;
        int w0;
        wr8(3'd4, 8'h95);
        chk("R2 cmd ce_n/cle/ale", {29'd0, nand_ce_n, nand_cle, nand_ale}, 32'd2);
        rd8(3'd4, v); chk("R2 mode readback", {24'd0, v}, 32'h95);
        w0 = wcnt;
        xfer(1'b1, 3'd0, 2'd0, 32'h0000_00FF, d);
        idle(1);
        chk("R2 command byte with CLE", {23'd0, wcle[w0 % 16], wlog[w0 % 16]}, 32'h1FF);
        wr8(3'd4, 8'h96);
        chk("R2 addr ce_n/cle/ale", {29'd0, nand_ce_n, nand_cle, nand_ale}, 32'd1);
        wr8(3'd4, 8'h00);
        chk("R2 standby ce_n", {31'd0, nand_ce_n}, 32'd1);
    endtask

    task automatic t_power;
        wr8(3'd4, 8'h0C); chk("R3 power on", {31'd0, card_pwr}, 32'd1);
        wr8(3'd4, 8'h94); chk("R3 bit3 clear keeps power", {31'd0, card_pwr}, 32'd1);
        wr8(3'd4, 8'h08); chk("R3 power off", {31'd0, card_pwr}, 32'd0);
    endtask

    task automatic t_write_sizes;
        logic [31:0] d;
        int w0;
        wr8(3'd4, 8'h94);
        w0 = wcnt;
        xfer(1'b1, 3'd0, 2'd0, 32'h1122_335A, d);
        idle(1);
        chk("R4 byte write count", 32'(wcnt - w0), 32'd1);
        chk("R4 byte value", {24'd0, wlog[w0 % 16]}, 32'h5A);
        chk("R6 strobe width", 32'(last_width), 32'(TB_STROBE));
        w0 = wcnt;
        xfer(1'b1, 3'd0, 2'd1, 32'h0000_1234, d);
        idle(1);
        chk("R4 half write count", 32'(wcnt - w0), 32'd2);
        chk("R4 half order", {16'd0, wlog[(w0 + 1) % 16], wlog[w0 % 16]}, 32'h1234);
        chk("R6 gap between strobes", 32'(wgap[(w0 + 1) % 16]), 32'd1);
        w0 = wcnt;
        xfer(1'b1, 3'd2, 2'd2, 32'hDEAD_BEEF, d);
        idle(1);
        chk("R4 word write count", 32'(wcnt - w0), 32'd4);
        chk("R4 word order", {wlog[(w0 + 3) % 16], wlog[(w0 + 2) % 16],
                              wlog[(w0 + 1) % 16], wlog[w0 % 16]}, 32'hDEAD_BEEF);
    endtask

    task automatic t_read_sizes;
        logic [31:0] d;
        int p;
        p = rd_ptr;
        xfer(1'b0, 3'd0, 2'd1, 32'd0, d);
        chk("R5 half read", d, {16'd0, rpat(p + 1), rpat(p)});
        p = rd_ptr;
        xfer(1'b0, 3'd1, 2'd0, 32'd0, d);
        chk("R5 byte read", d, {24'd0, rpat(p)});
        p = rd_ptr;
        xfer(1'b0, 3'd0, 2'd2, 32'd0, d);
        chk("R5 word read", d, {rpat(p + 3), rpat(p + 2), rpat(p + 1), rpat(p)});
    endtask

    task automatic t_write_gate;
        logic [31:0] d;
        int w0;
        wr8(3'd4, 8'h14);
        w0 = wcnt;
        xfer(1'b1, 3'd0, 2'd1, 32'h0000_ABCD, d);
        idle(2);
        chk("R7 no write strobe", 32'(wcnt - w0), 32'd0);
        chk("R7 access completed", 32'(last_lat), 32'(2 * (TB_STROBE + 1) + 1));
    endtask

    task automatic t_status;
        logic [7:0] v;
        nand_rb = 1'b0; idle(5);
        rd8(3'd5, v); chk("R8 busy", {24'd0, v}, 32'h80);
        nand_rb = 1'b1; idle(5);
        rd8(3'd5, v); chk("R8 ready", {24'd0, v}, 32'h00);
    endtask

    task automatic t_irq;
        logic [7:0] v;
        wr8(3'd6, 8'h0F);
        wr8(3'd7, 8'h81);
        nand_rb = 1'b0; idle(5);
        rd8(3'd6, v); chk("R9 no flag while busy", {24'd0, v}, 32'h00);
        nand_rb = 1'b1; idle(6);
        rd8(3'd6, v); chk("R9 flag on ready edge", {24'd0, v}, 32'h01);
        chk("R11 irq enabled", {31'd0, irq}, 32'd1);
        wr8(3'd6, 8'h0F);
        idle(6);
        rd8(3'd6, v); chk("R10 cleared, R9 level does not reset", {24'd0, v}, 32'h00);
        chk("R11 irq drops with flag", {31'd0, irq}, 32'd0);
        wr8(3'd7, 8'h00);
        nand_rb = 1'b0; idle(5);
        nand_rb = 1'b1; idle(6);
        rd8(3'd6, v); chk("R9 flag with mask off", {24'd0, v}, 32'h01);
        chk("R11 irq masked", {31'd0, irq}, 32'd0);
        wr8(3'd7, 8'h81);
        idle(2);
        chk("R11 irq after enable", {31'd0, irq}, 32'd1);
        wr8(3'd6, 8'h0F);
    endtask

    task automatic t_collide;
        logic [7:0] v;
        wr8(3'd6, 8'h0F);
        nand_rb = 1'b0; idle(6);
        rd8(3'd6, v); chk("R10 flag clear before edge", {24'd0, v}, 32'h00);
        // rb rises at negedge N0; synchronised edge sets the flag on the third
        // rising edge after; the clear request raised at N2 is accepted there too.
        @(negedge clk); nand_rb = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = 3'd6; bus_size = 2'd0; bus_wdata = 32'h0F;
        @(negedge clk);
        chk("R12 clear accepted", {31'd0, bus_ack}, 32'd1);
        bus_req = 1'b0;
        rd8(3'd6, v); chk("R10 set wins over clear", {24'd0, v}, 32'h01);
        wr8(3'd6, 8'h0F);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_ack();
        t_mode();
        t_power();
        t_write_sizes();
        t_read_sizes();
        t_write_gate();
        t_status();
        t_irq();
        t_collide();
        idle(4);
        report();
    end

endmodule